// File: doc/BRIEF.md
# Dual-Bank Transmit Mode Controller

This block turns two stored control banks and a handful of shared configuration fields into the enable and gain controls that drive the analog stages of a narrow-band transmitter. Each bank holds a power-amplifier code, an oscillator enable and a synthesizer enable. A mode pin picks which bank is live. Flipping that pin moves the transmitter between two fully prepared configurations, such as two carrier channels, with no reprogramming. An active-low standby pin overrides both banks and shuts every stage down. The bank contents themselves are held by the surrounding register file and are not disturbed by standby.

The shared fields set the feedback divider ratio (256 or 512), the multiplier for the acquisition-aid charge pump (1, or a multiple of 20 up to 140), and whether the data input may modulate the carrier. The acquisition-aid pump is enabled only while the synthesizer runs and the loop reports that it is not locked. Every output is registered, so it follows a change on any input one clock later.

Top module: `txmode_ctrl`

## Requirements
- R1: While reset is asserted, and right after it is released, pa_on, osc_on, synth_on, fsk_en and acq_pump_on are 0, pa_atten is 0, div_ratio is 256 and acq_mult is 1. Reset acts asynchronously.
- R2: mode_sel=0 selects bank0_ctl and mode_sel=1 selects bank1_ctl. The outputs reflect the newly selected bank on the first rising clock edge after the pin changes, and not before it.
- R3: The power-amplifier code in bits [1:0] of the live bank decodes as follows: 00 gives pa_on=0 and pa_atten=0; 01 gives pa_on=1 and pa_atten=10; 10 gives pa_on=1 and pa_atten=20; 11 gives pa_on=1 and pa_atten=0. pa_atten is given in dB.
- R4: While standby_n=0, pa_on, osc_on, synth_on, fsk_en and acq_pump_on are 0 and pa_atten is 0. When standby_n returns to 1 with the banks unchanged, the outputs return to the values of the live bank.
- R5: acq_mult is 1 for acq_code 000. For any other code it is 20 times the code, so 111 gives 140.
- R6: div_ratio is 256 when div_sel=0 and 512 when div_sel=1. It is not affected by standby.
- R7: acq_pump_on is 1 only while synth_on would be 1 and lock_det is 0. A high lock_det turns it off on the next edge.
- R8: fsk_en is 1 when the live power-amplifier code is non-zero, fsk_off=0 and standby_n=1. Otherwise it is 0.
- R9: Bit [2] of the live bank drives osc_on and bit [3] drives synth_on. The two bits are independent of each other and of the amplifier code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | Bank select: 0 selects bank 0, 1 selects bank 1 |
| standby_n | input | 1 | Active-low standby; 0 powers all stages down |
| lock_det | input | 1 | Loop lock indication, 1 = locked |
| fsk_off | input | 1 | 1 stops the data input from modulating the carrier |
| acq_code | input | 3 | Acquisition-aid multiplier code |
| div_sel | input | 1 | Divider ratio select (0: 256, 1: 512) |
| bank0_ctl | input | 4 | Bank 0: {synth enable, osc enable, PA code[1:0]} |
| bank1_ctl | input | 4 | Bank 1: same layout as bank 0 |
| pa_on | output | 1 | Power amplifier enable |
| pa_atten | output | 5 | Amplifier attenuation in dB (0, 10 or 20) |
| osc_on | output | 1 | Oscillator enable |
| synth_on | output | 1 | Synthesizer and loop enable |
| fsk_en | output | 1 | Modulation from the data input enabled |
| acq_pump_on | output | 1 | Acquisition-aid charge pump enable |
| div_ratio | output | 10 | Feedback divider ratio |
| acq_mult | output | 8 | Acquisition-aid current multiplier |

## Verification
The assertions assume that every control input is synchronous to clk and stable around each rising edge. Under that assumption, each output can be related to the inputs sampled on the previous edge. They also assume that lock_det is a plain level, with no pulses shorter than a clock. The bench meets both assumptions by changing every input on the falling edge only and holding it for at least one full cycle. It samples results one time unit after the rising edge. The one exception is reset, which the bench deliberately drives between edges to show that it acts asynchronously.

// File: rtl/txmode_pkg.sv
package txmode_pkg;

  // One control bank: {synth enable, osc enable, amplifier code}
  typedef struct packed {
    logic       synth_en;
    logic       osc_en;
    logic [1:0] pa_code;
  } bank_t;

  localparam logic [1:0] PA_OFF    = 2'b00;
  localparam logic [1:0] PA_ATT_LO = 2'b01;
  localparam logic [1:0] PA_ATT_HI = 2'b10;
  localparam logic [1:0] PA_FULL   = 2'b11;

endpackage

// File: rtl/txmode_bank_sel.sv
module txmode_bank_sel
  import txmode_pkg::*;
(
  input  logic  sel,
  input  bank_t bank_a,
  input  bank_t bank_b,
  output bank_t live
);

  always_comb begin
    live = sel ? bank_b : bank_a;
  end

endmodule

// File: rtl/txmode_pa_decode.sv
module txmode_pa_decode
  import txmode_pkg::*;
#(
  parameter int ATTEN_STEP = 10,
  parameter int ATTEN_W    = 5
) (
  input  logic [1:0]         code,
  output logic               amp_on,
  output logic [ATTEN_W-1:0] atten
);

  localparam logic [ATTEN_W-1:0] ATT_ONE = ATTEN_W'(ATTEN_STEP);
  localparam logic [ATTEN_W-1:0] ATT_TWO = ATTEN_W'(2 * ATTEN_STEP);

  // The mapping is not monotonic: the top code is full power.
  always_comb begin
    amp_on = (code != PA_OFF);
    unique case (code)
      PA_ATT_LO: atten = ATT_ONE;
      PA_ATT_HI: atten = ATT_TWO;
      default:   atten = '0;
    endcase
  end

endmodule

// File: rtl/txmode_shared_decode.sv
module txmode_shared_decode #(
  parameter int ACQ_W        = 3,
  parameter int ACQ_STEP     = 20,
  parameter int MULT_W       = 8,
  parameter int DIV_MIN_LOG2 = 8,
  parameter int DIV_W        = DIV_MIN_LOG2 + 2
) (
  input  logic [ACQ_W-1:0]  acq_code,
  input  logic              div_sel,
  output logic [MULT_W-1:0] mult,
  output logic [DIV_W-1:0]  ratio
);

  localparam logic [MULT_W-1:0] STEP_V = MULT_W'(ACQ_STEP);
  localparam logic [DIV_W-1:0]  DIV_LO = DIV_W'(1) << DIV_MIN_LOG2;

  always_comb begin
    if (acq_code == '0) mult = MULT_W'(1);
    else                mult = MULT_W'(acq_code) * STEP_V;
    ratio = div_sel ? (DIV_LO << 1) : DIV_LO;
  end

endmodule

// File: rtl/txmode_ctrl.sv
module txmode_ctrl
  import txmode_pkg::*;
#(
  parameter int ATTEN_STEP   = 10,
  parameter int ATTEN_W      = 5,
  parameter int ACQ_W        = 3,
  parameter int ACQ_STEP     = 20,
  parameter int MULT_W       = 8,
  parameter int DIV_MIN_LOG2 = 8,
  parameter int DIV_W        = DIV_MIN_LOG2 + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_sel,
  input  logic              standby_n,
  input  logic              lock_det,
  input  logic              fsk_off,
  input  logic [ACQ_W-1:0]  acq_code,
  input  logic              div_sel,
  input  logic [3:0]        bank0_ctl,
  input  logic [3:0]        bank1_ctl,
  output logic              pa_on,
  output logic [ATTEN_W-1:0] pa_atten,
  output logic              osc_on,
  output logic              synth_on,
  output logic              fsk_en,
  output logic              acq_pump_on,
  output logic [DIV_W-1:0]  div_ratio,
  output logic [MULT_W-1:0] acq_mult
);

  localparam logic [DIV_W-1:0]  DIV_RST  = DIV_W'(1) << DIV_MIN_LOG2;
  localparam logic [MULT_W-1:0] MULT_RST = MULT_W'(1);

  bank_t               live;
  logic                amp_dec;
  logic [ATTEN_W-1:0]  att_dec;
  logic [MULT_W-1:0]   mult_dec;
  logic [DIV_W-1:0]    ratio_dec;

  logic                pa_on_d, osc_on_d, synth_on_d, fsk_en_d, pump_d;
  logic [ATTEN_W-1:0]  atten_d;
  logic                upd_en;

  txmode_bank_sel u_sel (
    .sel    (mode_sel),
    .bank_a (bank_t'(bank0_ctl)),
    .bank_b (bank_t'(bank1_ctl)),
    .live   (live)
  );

  txmode_pa_decode #(.ATTEN_STEP(ATTEN_STEP), .ATTEN_W(ATTEN_W)) u_pa (
    .code   (live.pa_code),
    .amp_on (amp_dec),
    .atten  (att_dec)
  );

  txmode_shared_decode #(
    .ACQ_W(ACQ_W), .ACQ_STEP(ACQ_STEP), .MULT_W(MULT_W),
    .DIV_MIN_LOG2(DIV_MIN_LOG2), .DIV_W(DIV_W)
  ) u_shared (
    .acq_code (acq_code),
    .div_sel  (div_sel),
    .mult     (mult_dec),
    .ratio    (ratio_dec)
  );

  // Next-state: standby forces every stage enable low.
  always_comb begin
    upd_en     = 1'b1;
    pa_on_d    = standby_n & amp_dec;
    atten_d    = standby_n ? att_dec : '0;
    osc_on_d   = standby_n & live.osc_en;
    synth_on_d = standby_n & live.synth_en;
    fsk_en_d   = standby_n & amp_dec & ~fsk_off;
    pump_d     = standby_n & live.synth_en & ~lock_det;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_on       <= 1'b0;
      pa_atten    <= '0;
      osc_on      <= 1'b0;
      synth_on    <= 1'b0;
      fsk_en      <= 1'b0;
      acq_pump_on <= 1'b0;
      div_ratio   <= DIV_RST;
      acq_mult    <= MULT_RST;
    end else if (upd_en) begin
      pa_on       <= pa_on_d;
      pa_atten    <= atten_d;
      osc_on      <= osc_on_d;
      synth_on    <= synth_on_d;
      fsk_en      <= fsk_en_d;
      acq_pump_on <= pump_d;
      div_ratio   <= ratio_dec;
      acq_mult    <= mult_dec;
    end
  end

endmodule

// File: rtl/txmode_ctrl_chk.sv
module txmode_ctrl_chk #(
  parameter int ATTEN_W      = 5,
  parameter int ACQ_W        = 3,
  parameter int MULT_W       = 8,
  parameter int DIV_MIN_LOG2 = 8,
  parameter int DIV_W        = DIV_MIN_LOG2 + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_sel,
  input logic              standby_n,
  input logic              lock_det,
  input logic              fsk_off,
  input logic [ACQ_W-1:0]  acq_code,
  input logic              div_sel,
  input logic [3:0]        bank0_ctl,
  input logic [3:0]        bank1_ctl,
  input logic              pa_on,
  input logic [ATTEN_W-1:0] pa_atten,
  input logic              osc_on,
  input logic              synth_on,
  input logic              fsk_en,
  input logic              acq_pump_on,
  input logic [DIV_W-1:0]  div_ratio,
  input logic [MULT_W-1:0] acq_mult
);

  localparam logic [DIV_W-1:0] DIV_LO = DIV_W'(1) << DIV_MIN_LOG2;

  p_bank0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (standby_n && !mode_sel) |=> (osc_on == $past(bank0_ctl[2]) && synth_on == $past(bank0_ctl[3])));

  p_bank1_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (standby_n && mode_sel) |=> (osc_on == $past(bank1_ctl[2]) && synth_on == $past(bank1_ctl[3])));

  p_pa_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !pa_on |-> (pa_atten == '0 && !fsk_en));

  p_standby_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !standby_n |=> (!pa_on && !osc_on && !synth_on && !fsk_en && !acq_pump_on));

  p_mult_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_code == '0) |=> (acq_mult == MULT_W'(1)));

  p_div_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (div_ratio == ($past(div_sel) ? (DIV_LO << 1) : DIV_LO)));

  p_pump_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_det |=> !acq_pump_on);

  p_pump_synth_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acq_pump_on |-> synth_on);

  p_fsk_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fsk_off |=> !fsk_en);

endmodule

bind txmode_ctrl txmode_ctrl_chk #(
  .ATTEN_W(ATTEN_W), .ACQ_W(ACQ_W), .MULT_W(MULT_W),
  .DIV_MIN_LOG2(DIV_MIN_LOG2), .DIV_W(DIV_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .standby_n(standby_n),
  .lock_det(lock_det), .fsk_off(fsk_off), .acq_code(acq_code), .div_sel(div_sel),
  .bank0_ctl(bank0_ctl), .bank1_ctl(bank1_ctl), .pa_on(pa_on), .pa_atten(pa_atten),
  .osc_on(osc_on), .synth_on(synth_on), .fsk_en(fsk_en), .acq_pump_on(acq_pump_on),
  .div_ratio(div_ratio), .acq_mult(acq_mult)
);

// File: tb/txmode_ctrl_test.sv
module txmode_ctrl_test;

  typedef struct packed {
    logic       mode;
    logic       stby;
    logic       lock;
    logic       fsk_off;
    logic [2:0] acq;
    logic       div;
    logic [3:0] b0;
    logic [3:0] b1;
  } stim_t;

  typedef struct packed {
    logic       pa_on;
    logic [4:0] att;
    logic       osc;
    logic       syn;
    logic       fsk;
    logic       pump;
    logic [7:0] mult;
    logic [9:0] div;
  } exp_t;

  typedef struct packed {
    stim_t s;
    exp_t  e;
  } row_t;

  // bank = {synth, osc, pa[1:0]}
  localparam row_t TBL [0:7] = '{
    {1'b0,1'b1,1'b0,1'b0,3'd0,1'b0,4'b1111,4'b0000, 1'b1,5'd0, 1'b1,1'b1,1'b1,1'b1,8'd1,  10'd256},
    {1'b1,1'b1,1'b0,1'b0,3'd1,1'b1,4'b1111,4'b0001, 1'b1,5'd10,1'b0,1'b0,1'b1,1'b0,8'd20, 10'd512},
    {1'b1,1'b1,1'b1,1'b0,3'd2,1'b0,4'b1111,4'b1010, 1'b1,5'd20,1'b0,1'b1,1'b1,1'b0,8'd40, 10'd256},
    {1'b0,1'b1,1'b0,1'b0,3'd3,1'b0,4'b1100,4'b1010, 1'b0,5'd0, 1'b1,1'b1,1'b0,1'b1,8'd60, 10'd256},
    {1'b0,1'b0,1'b0,1'b0,3'd4,1'b0,4'b1111,4'b1010, 1'b0,5'd0, 1'b0,1'b0,1'b0,1'b0,8'd80, 10'd256},
    {1'b1,1'b1,1'b0,1'b1,3'd5,1'b1,4'b1111,4'b0111, 1'b1,5'd0, 1'b1,1'b0,1'b0,1'b0,8'd100,10'd512},
    {1'b0,1'b1,1'b0,1'b0,3'd6,1'b0,4'b1001,4'b0000, 1'b1,5'd10,1'b0,1'b1,1'b1,1'b1,8'd120,10'd256},
    {1'b1,1'b1,1'b0,1'b0,3'd7,1'b0,4'b1111,4'b0110, 1'b1,5'd20,1'b1,1'b0,1'b1,1'b0,8'd140,10'd256}
  };

  localparam string TAGS [0:7] = '{
    "R3 R5 R7 full power bank0", "R2 R3 R6 bank1 10dB", "R3 R7 locked 20dB", "R9 R3 pa off",
    "R4 standby", "R8 R6 fsk_off", "R5 R7 bank0 10dB", "R2 R3 bank1 20dB"
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       mode_sel, standby_n, lock_det, fsk_off, div_sel;
  logic [2:0] acq_code;
  logic [3:0] bank0_ctl, bank1_ctl;
  logic       pa_on, osc_on, synth_on, fsk_en, acq_pump_on;
  logic [4:0] pa_atten;
  logic [9:0] div_ratio;
  logic [7:0] acq_mult;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  txmode_ctrl uut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .standby_n(standby_n),
    .lock_det(lock_det), .fsk_off(fsk_off), .acq_code(acq_code), .div_sel(div_sel),
    .bank0_ctl(bank0_ctl), .bank1_ctl(bank1_ctl), .pa_on(pa_on), .pa_atten(pa_atten),
    .osc_on(osc_on), .synth_on(synth_on), .fsk_en(fsk_en), .acq_pump_on(acq_pump_on),
    .div_ratio(div_ratio), .acq_mult(acq_mult)
  );

  function automatic exp_t actual();
    return {pa_on, pa_atten, osc_on, synth_on, fsk_en, acq_pump_on, acq_mult, div_ratio};
  endfunction

  task automatic check(input exp_t e, input string tag);
    exp_t a;
    a = actual();
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, a, e);
    end
  endtask

  task automatic set_in(input stim_t s);
    mode_sel  = s.mode;
    standby_n = s.stby;
    lock_det  = s.lock;
    fsk_off   = s.fsk_off;
    acq_code  = s.acq;
    div_sel   = s.div;
    bank0_ctl = s.b0;
    bank1_ctl = s.b1;
  endtask

  task automatic apply(input stim_t s);
    @(negedge clk);
    set_in(s);
    @(posedge clk);
    #1;
  endtask

  localparam exp_t RST_E = {1'b0,5'd0,1'b0,1'b0,1'b0,1'b0,8'd1,10'd256};

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    stim_t s;
    rst_n = 1'b0;
    set_in({1'b0,1'b1,1'b0,1'b0,3'd3,1'b1,4'b1111,4'b1111});
    repeat (3) @(posedge clk);
    #1 check(RST_E, "R1 held in reset");
    @(negedge clk) rst_n = 1'b1;
    #1 check(RST_E, "R1 just released");

    for (int i = 0; i < 8; i++) begin
      apply(TBL[i].s);
      check(TBL[i].e, TAGS[i]);
    end

    // R2: the bank change appears at the next edge, not earlier
    apply({1'b0,1'b1,1'b0,1'b0,3'd0,1'b0,4'b1111,4'b0000});
    @(negedge clk);
    mode_sel = 1'b1;
    #1 check({1'b1,5'd0,1'b1,1'b1,1'b1,1'b1,8'd1,10'd256}, "R2 before edge");
    @(posedge clk);
    #1 check({1'b0,5'd0,1'b0,1'b0,1'b0,1'b0,8'd1,10'd256}, "R2 after edge");

    // R9: osc and synth bits independent of each other and the PA code
    apply({1'b1,1'b1,1'b0,1'b0,3'd0,1'b0,4'b0000,4'b0100});
    check({1'b0,5'd0,1'b1,1'b0,1'b0,1'b0,8'd1,10'd256}, "R9 osc only");

    // R4: standby and release with banks untouched
    s = {1'b0,1'b1,1'b0,1'b0,3'd1,1'b1,4'b1110,4'b0000};
    apply(s);
    check({1'b1,5'd20,1'b1,1'b1,1'b1,1'b1,8'd20,10'd512}, "R4 before standby");
    s.stby = 1'b0;
    apply(s);
    check({1'b0,5'd0,1'b0,1'b0,1'b0,1'b0,8'd20,10'd512}, "R4 in standby");
    apply(s);
    check({1'b0,5'd0,1'b0,1'b0,1'b0,1'b0,8'd20,10'd512}, "R4 still standby");
    s.stby = 1'b1;
    apply(s);
    check({1'b1,5'd20,1'b1,1'b1,1'b1,1'b1,8'd20,10'd512}, "R4 restored");

    // R7: lock toggling
    s.lock = 1'b1;
    apply(s);
    check({1'b1,5'd20,1'b1,1'b1,1'b1,1'b0,8'd20,10'd512}, "R7 locked");
    s.lock = 1'b0;
    apply(s);
    check({1'b1,5'd20,1'b1,1'b1,1'b1,1'b1,8'd20,10'd512}, "R7 lock lost");

    // R1: asynchronous reset between edges
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1 check(RST_E, "R1 async reset");
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk);
    #1 check({1'b1,5'd20,1'b1,1'b1,1'b1,1'b1,8'd20,10'd512}, "R1 recover");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule